// File: doc/BRIEF.md
# I2C Serial EEPROM Target

This block is an I2C-bus target that fronts a 512-byte memory held in a register file. It samples SCL and SDA with the system clock, finds START, repeated START and STOP, and decodes a slave address whose upper nibble is the device-type code 1010. Two chip-select bits must match the `pin_a2`/`pin_a1` inputs. A third bit, sent by the master, picks the lower or upper 256-byte half. SDA is driven open-drain: `sda_oe` high pulls the line low.

Writes go into an eight-byte page buffer and are committed to the array on STOP. After a commit the block refuses its slave address for `BUSY_CYCLES` clocks, which models the write time. Reads come directly from the array through an internal address counter. That counter is set by a word-address byte and advances after every byte. With `wp` high, data bytes aimed at the upper half are refused and dropped.

The controller is one state machine with these states. `ST_IDLE` waits for START. `ST_DEVADDR` shifts in the slave address, then moves to `ST_DEVACK` on a match or back to `ST_IDLE` otherwise. `ST_DEVACK` goes to `ST_WORDADDR` for a write or to `ST_RDDATA` for a read. `ST_WORDADDR` is followed by `ST_WORDACK`, which leads to `ST_WRDATA`. `ST_WRDATA` goes to `ST_WRACK` when it accepts a byte and to `ST_WRSKIP` when it refuses one; both return to `ST_WRDATA`. `ST_RDDATA` is followed by `ST_RDACK`, which returns to `ST_RDDATA` on a master ACK and goes to `ST_IDLE` on a NACK. A START from any state moves to `ST_DEVADDR`, and a STOP from any state moves to `ST_IDLE`.

Top module: `i2c_eeprom_target`

## Requirements
- R1: After reset `sda_oe` is low, the address counter is 0 and every memory byte reads 0.
- R2: The block acknowledges only a slave address of the form 1010,A2,A1,H,RW (MSB first), where A2/A1 equal `pin_a2`/`pin_a1`. On a mismatch it does not acknowledge that byte or any later byte until the next START. SDA is only driven while in `ST_DEVACK`, `ST_WORDACK`, `ST_WRACK` or `ST_RDDATA`.
- R3: A byte write is address (RW=0), word address, then one data byte, each acknowledged. Afterwards the counter points to the next location.
- R4: A page write accepts any number of data bytes and acknowledges each one. The counter wraps within the aligned eight-byte page, so a ninth byte overwrites the first.
- R5: A random read returns the byte at a word address written just before a repeated START with RW=1.
- R6: Bit H of the slave address selects the half (0 = lower, 1 = upper). Sequential reads wrap from offset 255 to 0 inside that half.
- R7: With `wp` high, the slave address and word address are acknowledged. Data bytes bound for the upper half are not acknowledged and never reach the array. Lower-half writes are unaffected.
- R8: Buffered bytes are committed on STOP. For `BUSY_CYCLES` clocks afterwards the slave address is not acknowledged.
- R9: Read data leaves MSB first. SDA changes only while SCL is low. After a master NACK the block releases SDA, and it releases SDA at STOP.
- R10: Data bytes buffered before a repeated START are discarded, not committed, and start no busy period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | High pulls SDA low (open-drain drive) |
| pin_a2 | input | 1 | Chip-select bit matched against address bit 3 |
| pin_a1 | input | 1 | Chip-select bit matched against address bit 2 |
| wp | input | 1 | High protects the upper 256 bytes from writes |

## Verification
The assertions assume that `wp` stays stable from the acceptance of a data byte until its commit has finished. They also assume that each SCL phase lasts several system clocks, so edge detection sees every transition. The master never issues START or STOP while the block is driving data. The stimulus follows all of these rules: it changes `wp` only between transactions on an idle bus, keeps every SCL quarter-phase at eight clocks, and changes SDA only while SCL is low, except for START and STOP.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

    localparam int BYTE_W = 8;
    localparam logic [3:0] DEV_TYPE = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEVADDR,
        ST_DEVACK,
        ST_WORDADDR,
        ST_WORDACK,
        ST_WRDATA,
        ST_WRACK,
        ST_WRSKIP,
        ST_RDDATA,
        ST_RDACK
    } bus_state_t;

endpackage

// File: rtl/i2c_line_monitor.sv
module i2c_line_monitor #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [SYNC_STAGES-1:0] scl_sync;
    logic [SYNC_STAGES-1:0] sda_sync;
    logic scl_prev;
    logic sda_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sync <= '1;
            sda_sync <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
            sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
            scl_prev <= scl_sync[SYNC_STAGES-1];
            sda_prev <= sda_sync[SYNC_STAGES-1];
        end
    end

    assign scl_lvl   = scl_sync[SYNC_STAGES-1];
    assign sda_lvl   = sda_sync[SYNC_STAGES-1];
    assign scl_rise  = scl_lvl & ~scl_prev;
    assign scl_fall  = ~scl_lvl & scl_prev;
    assign start_det = scl_lvl & scl_prev & ~sda_lvl & sda_prev;
    assign stop_det  = scl_lvl & scl_prev & sda_lvl & ~sda_prev;

endmodule

// File: rtl/eeprom_store.sv
module eeprom_store #(
    parameter int DEPTH = 512,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
        end else if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/page_buffer.sv
module page_buffer #(
    parameter int PAGE        = 8,
    parameter int DW          = 8,
    parameter int AW          = 9,
    parameter int BUSY_CYCLES = 600,
    localparam int IW         = $clog2(PAGE),
    localparam int CW         = $clog2(BUSY_CYCLES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             load,
    input  logic [IW-1:0]    load_idx,
    input  logic [DW-1:0]    load_data,
    input  logic             commit,
    input  logic [AW-IW-1:0] page_base,
    output logic             busy,
    output logic             mem_we,
    output logic [AW-1:0]    mem_waddr,
    output logic [DW-1:0]    mem_wdata
);

    logic [DW-1:0]    slot [PAGE];
    logic [PAGE-1:0]  filled;
    logic [AW-IW-1:0] base_q;
    logic [CW-1:0]    tick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < PAGE; i++) slot[i] <= '0;
            filled <= '0;
            base_q <= '0;
            tick   <= '0;
            busy   <= 1'b0;
        end else if (busy) begin
            if (tick == CW'(BUSY_CYCLES - 1)) begin
                busy   <= 1'b0;
                filled <= '0;
            end
            tick <= tick + 1'b1;
        end else if (commit && |filled) begin
            busy   <= 1'b1;
            tick   <= '0;
            base_q <= page_base;
        end else if (clear) begin
            filled <= '0;
        end else if (load) begin
            slot[load_idx]   <= load_data;
            filled[load_idx] <= 1'b1;
        end
    end

    assign mem_we    = busy && (tick < CW'(PAGE)) && filled[tick[IW-1:0]];
    assign mem_waddr = {base_q, tick[IW-1:0]};
    assign mem_wdata = slot[tick[IW-1:0]];

endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
    import eeprom_pkg::*;
#(
    parameter int MEM_BYTES   = 512,
    parameter int PAGE_BYTES  = 8,
    parameter int BUSY_CYCLES = 600,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe,
    input  logic pin_a2,
    input  logic pin_a1,
    input  logic wp
);

    localparam int AW = $clog2(MEM_BYTES);
    localparam int LW = AW - 1;
    localparam int IW = $clog2(PAGE_BYTES);

    bus_state_t state, state_d;

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] rdbyte;
    logic [3:0]        bitcnt;
    logic              rw_q;
    logic              half;
    logic [LW-1:0]     lo;
    logic              mack;
    logic              byte_done;
    logic              addr_ok;
    logic              protect;
    logic              busy;
    logic              buf_load;
    logic              mem_we;
    logic [AW-1:0]     mem_waddr;
    logic [BYTE_W-1:0] mem_wdata;
    logic [AW-1:0]     raddr;
    logic [BYTE_W-1:0] rdata;

    i2c_line_monitor #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
        .clk, .rst_n, .scl_i, .sda_i,
        .scl_lvl, .sda_lvl, .scl_rise, .scl_fall, .start_det, .stop_det
    );

    page_buffer #(
        .PAGE(PAGE_BYTES), .DW(BYTE_W), .AW(AW), .BUSY_CYCLES(BUSY_CYCLES)
    ) u_buf (
        .clk, .rst_n,
        .clear     (start_det),
        .load      (buf_load),
        .load_idx  (lo[IW-1:0]),
        .load_data (shreg),
        .commit    (stop_det),
        .page_base ({half, lo[LW-1:IW]}),
        .busy,
        .mem_we, .mem_waddr, .mem_wdata
    );

    eeprom_store #(.DEPTH(MEM_BYTES), .DW(BYTE_W)) u_store (
        .clk, .rst_n,
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr,
        .rdata
    );

    assign byte_done = scl_fall && (bitcnt == 4'd8);
    assign addr_ok   = (shreg[7:4] == DEV_TYPE) && (shreg[3] == pin_a2)
                       && (shreg[2] == pin_a1) && !busy;
    assign protect   = wp && half;
    assign buf_load  = (state == ST_WRDATA) && byte_done && !protect;
    assign raddr     = (state == ST_RDACK) ? {half, lo + 1'b1} : {half, lo};

    always_comb begin
        state_d = state;
        if (start_det) begin
            state_d = ST_DEVADDR;
        end else if (stop_det) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:     state_d = ST_IDLE;
                ST_DEVADDR:  if (byte_done) state_d = addr_ok ? ST_DEVACK : ST_IDLE;
                ST_DEVACK:   if (scl_fall) state_d = rw_q ? ST_RDDATA : ST_WORDADDR;
                ST_WORDADDR: if (byte_done) state_d = ST_WORDACK;
                ST_WORDACK:  if (scl_fall) state_d = ST_WRDATA;
                ST_WRDATA:   if (byte_done) state_d = protect ? ST_WRSKIP : ST_WRACK;
                ST_WRACK,
                ST_WRSKIP:   if (scl_fall) state_d = ST_WRDATA;
                ST_RDDATA:   if (scl_fall && bitcnt == 4'd7) state_d = ST_RDACK;
                ST_RDACK:    if (scl_fall) state_d = mack ? ST_RDDATA : ST_IDLE;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg  <= '0;
            rdbyte <= '0;
            bitcnt <= '0;
            rw_q   <= 1'b0;
            half   <= 1'b0;
            lo     <= '0;
            mack   <= 1'b0;
        end else if (start_det) begin
            bitcnt <= '0;
        end else begin
            case (state)
                ST_DEVADDR, ST_WORDADDR, ST_WRDATA: begin
                    if (scl_rise) begin
                        shreg  <= {shreg[BYTE_W-2:0], sda_lvl};
                        bitcnt <= bitcnt + 1'b1;
                    end
                    if (byte_done) begin
                        bitcnt <= '0;
                        if (state == ST_DEVADDR && addr_ok) begin
                            rw_q <= shreg[0];
                            half <= shreg[1];
                        end
                        if (state == ST_WORDADDR) lo <= LW'(shreg);
                        if (state == ST_WRDATA && !protect)
                            lo <= {lo[LW-1:IW], lo[IW-1:0] + 1'b1};
                    end
                end
                ST_DEVACK: begin
                    if (scl_fall && rw_q) begin
                        rdbyte <= rdata;
                        bitcnt <= '0;
                    end
                end
                ST_RDDATA: begin
                    if (scl_fall) bitcnt <= bitcnt + 1'b1;
                end
                ST_RDACK: begin
                    if (scl_rise) mack <= ~sda_lvl;
                    if (scl_fall) begin
                        lo     <= lo + 1'b1;
                        rdbyte <= rdata;
                        bitcnt <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (state)
            ST_DEVACK, ST_WORDACK, ST_WRACK: sda_oe = 1'b1;
            ST_RDDATA: sda_oe = ~rdbyte[~bitcnt[2:0]];
            default:   sda_oe = 1'b0;
        endcase
    end

endmodule

// File: rtl/eeprom_checker.sv
module eeprom_checker
    import eeprom_pkg::*;
#(
    parameter int AW = 9,
    parameter int IW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input bus_state_t    state,
    input logic          sda_oe,
    input logic          scl_lvl,
    input logic          stop_det,
    input logic          busy,
    input logic          wp,
    input logic          mem_we,
    input logic [AW-1:0] mem_waddr
);

    assert_busy_refuse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> state != ST_DEVACK);

    assert_release_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    assert_drive_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_lvl);

    assert_drive_states_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe |-> (state == ST_DEVACK || state == ST_WORDACK
                    || state == ST_WRACK || state == ST_RDDATA));

    assert_upper_guard_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && wp) |-> !mem_waddr[AW-1]);

    assert_page_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> mem_waddr[AW-1:IW] == $past(mem_waddr[AW-1:IW]));

endmodule

bind i2c_eeprom_target eeprom_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .sda_oe    (sda_oe),
    .scl_lvl   (scl_lvl),
    .stop_det  (stop_det),
    .busy      (busy),
    .wp        (wp),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr)
);

// File: tb/i2c_eeprom_target_test.sv
`timescale 1ns/1ps
module i2c_eeprom_target_test;

    localparam int Q    = 8;
    localparam int BUSY = 600;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic wp    = 1'b0;
    logic sda_oe;
    logic sda_line;
    assign sda_line = sda_m & ~sda_oe;

    i2c_eeprom_target #(.BUSY_CYCLES(BUSY)) uut (
        .clk, .rst_n,
        .scl_i  (scl_m),
        .sda_i  (sda_line),
        .sda_oe,
        .pin_a2 (1'b1),
        .pin_a1 (1'b0),
        .wp
    );

    int vectors = 0;
    int misses  = 0;
    logic [7:0] mem_m [512];
    int half_m = 0;
    int lo_m   = 0;
    int pend_a[$];
    int pend_d[$];

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            misses++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input bit b);
        sda_m = b; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic do_start();
        sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(2*Q);
        sda_m = 1'b0; tick(2*Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic do_stop();
        sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(2*Q); sda_m = 1'b1; tick(2*Q);
    endtask

    task automatic put_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
        ack = !sda_line;
        tick(Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic get_byte(input bit mack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q); scl_m = 1'b1; tick(Q); b[i] = sda_line; tick(Q); scl_m = 1'b0; tick(Q);
        end
        send_bit(!mack);
    endtask

    function automatic logic [7:0] devb(input bit h, input bit rw);
        return {4'b1010, 1'b1, 1'b0, h, rw};
    endfunction

    task automatic commit_model();
        for (int i = 0; i < pend_a.size(); i++) mem_m[pend_a[i]] = 8'(pend_d[i]);
        pend_a.delete(); pend_d.delete();
    endtask

    task automatic wr_xact(input bit h, input int word, input int n, input int seed,
                           input string tag, input bit wait_busy);
        bit ack; bit prot; int d; bit any;
        do_start();
        put_byte(devb(h, 1'b0), ack); chk({tag, " address ack"}, ack, 1);
        half_m = h;
        put_byte(8'(word), ack); chk({tag, " word ack"}, ack, 1);
        lo_m = word;
        for (int k = 0; k < n; k++) begin
            d = (seed + k * 37) & 255;
            prot = wp && h;
            put_byte(8'(d), ack); chk({tag, " data ack"}, ack, int'(!prot));
            if (!prot) begin
                pend_a.push_back(half_m * 256 + lo_m);
                pend_d.push_back(d);
                lo_m = (lo_m & 'hF8) | ((lo_m + 1) & 7);
            end
        end
        do_stop();
        any = pend_a.size() > 0;
        commit_model();
        if (any && wait_busy) tick(BUSY + 50);
    endtask

    task automatic rd_seq(input int n, input string tag);
        logic [7:0] b;
        for (int k = 0; k < n; k++) begin
            get_byte(k != n - 1, b);
            chk(tag, int'(b), int'(mem_m[half_m * 256 + lo_m]));
            lo_m = (lo_m + 1) & 255;
        end
        chk("R9 release after NACK", int'(sda_oe), 0);
        do_stop();
    endtask

    task automatic cur_read(input bit h, input int n, input string tag);
        bit ack;
        do_start(); pend_a.delete(); pend_d.delete();
        put_byte(devb(h, 1'b1), ack); chk({tag, " address ack"}, ack, 1);
        half_m = h;
        rd_seq(n, tag);
    endtask

    task automatic rnd_read(input bit h, input int word, input int n, input string tag);
        bit ack;
        do_start(); pend_a.delete(); pend_d.delete();
        put_byte(devb(h, 1'b0), ack); chk({tag, " address ack"}, ack, 1);
        half_m = h;
        put_byte(8'(word), ack); chk({tag, " word ack"}, ack, 1);
        lo_m = word;
        do_start();
        put_byte(devb(h, 1'b1), ack); chk({tag, " read address ack"}, ack, 1);
        rd_seq(n, tag);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        misses++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        bit ack;
        logic [7:0] b;
        for (int i = 0; i < 512; i++) mem_m[i] = 8'h00;
        rst_n = 1'b0;
        tick(10);
        rst_n = 1'b1;
        tick(5);

        // R1: idle line and cleared contents
        chk("R1 reset sda_oe", int'(sda_oe), 0);
        cur_read(1'b0, 2, "R1 reset contents");

        // R3: byte write then current-address read of the next location
        wr_xact(1'b0, 'h10, 1, 'hA5, "R3", 1'b1);
        cur_read(1'b0, 1, "R3 counter advanced");
        // R5: random read
        rnd_read(1'b0, 'h10, 1, "R5 random read");

        // R4: full page then a nine-byte write starting mid page
        wr_xact(1'b0, 'h20, 8, 'h11, "R4", 1'b1);
        rnd_read(1'b0, 'h20, 8, "R4 page data");
        wr_xact(1'b0, 'h2B, 9, 'h40, "R4", 1'b1);
        rnd_read(1'b0, 'h28, 8, "R4 page wrap");

        // R6: upper half, sequential read wraps within the half
        wr_xact(1'b1, 'hFE, 2, 'h90, "R6", 1'b1);
        rnd_read(1'b1, 'hFE, 4, "R6 half wrap");
        rnd_read(1'b0, 'hFE, 1, "R6 lower half untouched");

        // R7: write protect
        wp = 1'b1;
        tick(4);
        wr_xact(1'b1, 'h40, 2, 'h55, "R7", 1'b1);
        rnd_read(1'b1, 'h40, 2, "R7 protected unchanged");
        wr_xact(1'b0, 'h40, 1, 'h66, "R7", 1'b1);
        rnd_read(1'b0, 'h40, 1, "R7 lower half writable");
        wp = 1'b0;
        tick(4);

        // R2: chip-select and type mismatches are ignored
        do_start();
        put_byte({4'b1010, 1'b0, 1'b0, 1'b0, 1'b0}, ack); chk("R2 pin mismatch nack", ack, 0);
        put_byte(8'h10, ack); chk("R2 ignored word", ack, 0);
        put_byte(8'hEE, ack); chk("R2 ignored data", ack, 0);
        do_stop();
        do_start();
        put_byte({4'b1011, 1'b1, 1'b0, 1'b0, 1'b0}, ack); chk("R2 type mismatch nack", ack, 0);
        do_stop();
        rnd_read(1'b0, 'h10, 1, "R2 memory unchanged");

        // R8: busy period after commit
        wr_xact(1'b0, 'h60, 1, 'h3C, "R8", 1'b0);
        do_start();
        put_byte(devb(1'b0, 1'b1), ack); chk("R8 busy nack", ack, 0);
        do_stop();
        tick(BUSY + 50);
        rnd_read(1'b0, 'h60, 1, "R8 committed after busy");

        // R10: repeated START discards buffered bytes
        do_start();
        put_byte(devb(1'b0, 1'b0), ack); chk("R10 address ack", ack, 1);
        put_byte(8'h30, ack); chk("R10 word ack", ack, 1);
        put_byte(8'h77, ack); chk("R10 data ack", ack, 1);
        half_m = 0; lo_m = 'h31;
        do_start();
        put_byte(devb(1'b0, 1'b1), ack); chk("R10 read address ack", ack, 1);
        get_byte(1'b0, b); chk("R10 counter after data", int'(b), int'(mem_m['h31]));
        do_stop();
        rnd_read(1'b0, 'h30, 1, "R10 discarded data");

        finish_run();
    end

endmodule